// File: doc/BRIEF.md
# Configurable Cell Register

This block is the storage stage of a programmable logic cell. A static configuration chooses where its data comes from: the cell's XOR stage, a dedicated product term, or the pin. It also chooses how the stored bit is updated: as a D, T, JK or SR flip-flop, or as a transparent latch. The configuration picks the clock as well, which is one of several global clocks or a clock formed by a product term.

A clock-enable term can hold the register, but only while a global clock drives it. The asynchronous clear has four source settings and the asynchronous preset has two. A clear always beats a preset. The cell offers two outputs. The routed output and the buried feedback can each show either the stored bit or the combinational XOR result. This lets a cell drive logic onto its pin while it feeds a registered value back into the array.

All configuration inputs are static and are set while the block is idle. The power-on reset input clears the stored state.

Top module: `cellreg_top`

## Requirements
- R1: `cfg_dsrc` selects the data: 0 = XOR result, 1 = `data_pt`, 2 = `pin_in`. In D mode the selected value is stored at the active clock edge.
- R2: `cfg_mode` sets the update rule at the rising edge of the selected clock, with d the selected data and k = `k_pt`. The rules are: 0 = D (q=d), 1 = T (q toggles when d=1), 2 = JK (J=d, K=k; J=K=1 toggles), 3 = SR (S=d, R=k; S=R=1 holds, S=R=0 holds).
- R3: `cfg_mode` = 4 gives a latch. It is transparent while the selected clock is high, so the output follows the data. It holds while the clock is low.
- R4: `cfg_clk_sel` values 0..2 select `gclk[0..2]` and 3 selects `pt_clk`. Edges on clocks that are not selected leave the state unchanged.
- R5: When `cfg_ce_on`=1 and a global clock is selected, `ce_pt`=0 blocks every update, in both flop and latch modes. With `pt_clk` selected, `ce_pt` has no effect.
- R6: `cfg_rst_sel` clears the state asynchronously: 0 = off, 1 = `gclr`, 2 = `ar_pt`, 3 = `gclr` OR `ar_pt`.
- R7: When `cfg_pre_sel`=1, `ar_pt`... more precisely `ap_pt` sets the state to 1 asynchronously. When `cfg_pre_sel`=0, `ap_pt` is ignored. When an enabled clear and an enabled preset are both active, the state is 0. When the clear is then released while the preset is still held, the state becomes 1.
- R8: `cfg_out_reg`=1 routes the stored bit to `cell_out`, and 0 routes the XOR result. `cfg_fb_reg` selects the same pair for `fb_out`, independently of `cfg_out_reg`.
- R9: The XOR result is `sum_in` XOR b. `cfg_xsel` picks b: 0 = constant 0, 1 = constant 1, 2 = `xor_pt`.
- R10: While `rst_n` is low, the stored state is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| gclk | input | 3 | Global clocks |
| pt_clk | input | 1 | Product-term clock |
| gclr | input | 1 | Global asynchronous clear |
| cfg_mode | input | 3 | Storage mode |
| cfg_dsrc | input | 2 | Data source select |
| cfg_xsel | input | 2 | XOR second-input select |
| cfg_clk_sel | input | 2 | Clock select |
| cfg_ce_on | input | 1 | Clock enable in use |
| cfg_rst_sel | input | 2 | Clear source select |
| cfg_pre_sel | input | 1 | Preset enabled |
| cfg_out_reg | input | 1 | Cell output shows the stored bit |
| cfg_fb_reg | input | 1 | Feedback shows the stored bit |
| sum_in | input | 1 | OR sum term |
| xor_pt | input | 1 | Product term for the XOR |
| data_pt | input | 1 | Dedicated data product term |
| pin_in | input | 1 | Pin input |
| k_pt | input | 1 | K / R term for JK and SR modes |
| ce_pt | input | 1 | Clock enable term |
| ar_pt | input | 1 | Local clear term |
| ap_pt | input | 1 | Local preset term |
| cell_out | output | 1 | Routed cell output |
| fb_out | output | 1 | Buried feedback |

## Verification
The bench builds the block with its default of three global clocks, which gives a 2-bit clock select with no unused code. The bench can therefore step through every clock source, including the product-term clock. Because the cell holds a single bit, every flop mode can be swept over all starting states and both data and k values. The data source and XOR selects can be swept over every input pattern, and every clear setting over every combination of its two triggers. Cost is not a concern at this size, and it means each row of each update table is checked directly rather than sampled.

// File: rtl/cellreg_pkg.sv
package cellreg_pkg;

    typedef enum logic [2:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4
    } cell_mode_e;

    typedef enum logic [1:0] {
        DSRC_XOR = 2'd0,
        DSRC_PT  = 2'd1,
        DSRC_PIN = 2'd2
    } dsrc_e;

    typedef enum logic [1:0] {
        XB_ZERO = 2'd0,
        XB_ONE  = 2'd1,
        XB_PT   = 2'd2
    } xsel_e;

    typedef enum logic [1:0] {
        CLR_OFF    = 2'd0,
        CLR_GLOBAL = 2'd1,
        CLR_LOCAL  = 2'd2,
        CLR_BOTH   = 2'd3
    } clr_sel_e;

    typedef struct packed {
        logic stored;
    } cell_st_t;

endpackage

// File: rtl/cellreg_src.sv
module cellreg_src
    import cellreg_pkg::*;
(
    input  logic [1:0] dsrc,
    input  logic [1:0] xsel,
    input  logic       sum_in,
    input  logic       xor_pt,
    input  logic       data_pt,
    input  logic       pin_in,
    output logic       xor_out,
    output logic       dsel
);

    logic xb;

    // Second XOR input: fixed polarity or a product term.
    always_comb begin
        unique case (xsel_e'(xsel))
            XB_ZERO: xb = 1'b0;
            XB_ONE:  xb = 1'b1;
            XB_PT:   xb = xor_pt;
            default: xb = 1'b0;
        endcase
        xor_out = sum_in ^ xb;
    end

    // Data source for the storage element.
    always_comb begin
        unique case (dsrc_e'(dsrc))
            DSRC_XOR: dsel = xor_out;
            DSRC_PT:  dsel = data_pt;
            DSRC_PIN: dsel = pin_in;
            default:  dsel = xor_out;
        endcase
    end

endmodule

// File: rtl/cellreg_clkmux.sv
module cellreg_clkmux #(
    parameter int NUM_GCLK = 3,
    parameter int CSEL_W   = $clog2(NUM_GCLK + 1)
) (
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic [CSEL_W-1:0]   sel,
    input  logic                ce_on,
    input  logic                ce_pt,
    output logic                clk_out,
    output logic                upd_en
);

    localparam int NSRC = 1 << CSEL_W;

    logic [NSRC-1:0] src;
    logic            is_global;

    // Pad the source vector to a power of two so every code is decoded.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i < NUM_GCLK) begin : g_glob
            assign src[i] = gclk[i];
        end else if (i == NUM_GCLK) begin : g_pt
            assign src[i] = pt_clk;
        end else begin : g_none
            assign src[i] = 1'b0;
        end
    end

    always_comb begin
        clk_out   = src[sel];
        is_global = (32'(sel) < NUM_GCLK);
        // The enable term only matters when a global clock drives the cell.
        upd_en    = (is_global && ce_on) ? ce_pt : 1'b1;
    end

endmodule

// File: rtl/cellreg_async.sv
module cellreg_async
    import cellreg_pkg::*;
(
    input  logic       rst_n,
    input  logic       gclr,
    input  logic       ar_pt,
    input  logic       ap_pt,
    input  logic [1:0] rst_sel,
    input  logic       pre_sel,
    output logic       clr_eff,
    output logic       set_eff
);

    logic clr_cfg;

    always_comb begin
        unique case (clr_sel_e'(rst_sel))
            CLR_OFF:    clr_cfg = 1'b0;
            CLR_GLOBAL: clr_cfg = gclr;
            CLR_LOCAL:  clr_cfg = ar_pt;
            CLR_BOTH:   clr_cfg = gclr | ar_pt;
            default:    clr_cfg = 1'b0;
        endcase
        clr_eff = clr_cfg | ~rst_n;
        // A preset is masked while any clear is active, so clear dominates.
        set_eff = pre_sel & ap_pt & ~clr_eff;
    end

endmodule

// File: rtl/cellreg_next.sv
module cellreg_next
    import cellreg_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       din,
    input  logic       kin,
    input  logic       cur,
    output logic       nxt
);

    always_comb begin
        unique case (cell_mode_e'(mode))
            MODE_D:  nxt = din;
            // Toggle: current state fed back through an XOR.
            MODE_T:  nxt = cur ^ din;
            MODE_JK: nxt = (din & ~cur) | (~kin & cur);
            MODE_SR: begin
                if (din && !kin)      nxt = 1'b1;
                else if (kin && !din) nxt = 1'b0;
                else                  nxt = cur;
            end
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/cellreg_top.sv
module cellreg_top
    import cellreg_pkg::*;
#(
    parameter  int NUM_GCLK = 3,
    localparam int CSEL_W   = $clog2(NUM_GCLK + 1)
) (
    input  logic                rst_n,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                gclr,
    input  logic [2:0]          cfg_mode,
    input  logic [1:0]          cfg_dsrc,
    input  logic [1:0]          cfg_xsel,
    input  logic [CSEL_W-1:0]   cfg_clk_sel,
    input  logic                cfg_ce_on,
    input  logic [1:0]          cfg_rst_sel,
    input  logic                cfg_pre_sel,
    input  logic                cfg_out_reg,
    input  logic                cfg_fb_reg,
    input  logic                sum_in,
    input  logic                xor_pt,
    input  logic                data_pt,
    input  logic                pin_in,
    input  logic                k_pt,
    input  logic                ce_pt,
    input  logic                ar_pt,
    input  logic                ap_pt,
    output logic                cell_out,
    output logic                fb_out
);

    logic     xor_out;
    logic     dsel;
    logic     clk_mux;
    logic     upd_en;
    logic     clr_eff;
    logic     set_eff;
    logic     nxt;
    logic     lat_q;
    logic     state;
    cell_st_t st_d;
    cell_st_t st_q;

    cellreg_src u_src (
        .dsrc    (cfg_dsrc),
        .xsel    (cfg_xsel),
        .sum_in  (sum_in),
        .xor_pt  (xor_pt),
        .data_pt (data_pt),
        .pin_in  (pin_in),
        .xor_out (xor_out),
        .dsel    (dsel)
    );

    cellreg_clkmux #(
        .NUM_GCLK (NUM_GCLK),
        .CSEL_W   (CSEL_W)
    ) u_clk (
        .gclk    (gclk),
        .pt_clk  (pt_clk),
        .sel     (cfg_clk_sel),
        .ce_on   (cfg_ce_on),
        .ce_pt   (ce_pt),
        .clk_out (clk_mux),
        .upd_en  (upd_en)
    );

    cellreg_async u_async (
        .rst_n   (rst_n),
        .gclr    (gclr),
        .ar_pt   (ar_pt),
        .ap_pt   (ap_pt),
        .rst_sel (cfg_rst_sel),
        .pre_sel (cfg_pre_sel),
        .clr_eff (clr_eff),
        .set_eff (set_eff)
    );

    cellreg_next u_next (
        .mode (cfg_mode),
        .din  (dsel),
        .kin  (k_pt),
        .cur  (st_q.stored),
        .nxt  (nxt)
    );

    // Next value: a blocked enable recirculates the current state.
    always_comb begin
        st_d        = st_q;
        st_d.stored = upd_en ? nxt : st_q.stored;
    end

    always_ff @(posedge clk_mux or posedge clr_eff or posedge set_eff) begin
        if (clr_eff) begin
            st_q <= '0;
        end else if (set_eff) begin
            st_q <= '{stored: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // Flow-through storage for latch mode.
    always_latch begin
        if (clr_eff) begin
            lat_q <= 1'b0;
        end else if (set_eff) begin
            lat_q <= 1'b1;
        end else if (clk_mux && upd_en) begin
            lat_q <= dsel;
        end
    end

    always_comb begin
        state    = (cell_mode_e'(cfg_mode) == MODE_LATCH) ? lat_q : st_q.stored;
        cell_out = cfg_out_reg ? state : xor_out;
        fb_out   = cfg_fb_reg  ? state : xor_out;
    end

    // R6
    clear_holds_chk: assert property (@(posedge clk_mux) disable iff (!rst_n)
        clr_eff |-> !state);

    // R7
    preset_holds_chk: assert property (@(posedge clk_mux) disable iff (!rst_n)
        set_eff |-> state);

    // R5
    ce_block_chk: assert property (@(posedge clk_mux) disable iff (clr_eff || set_eff)
        (cell_mode_e'(cfg_mode) != MODE_LATCH && !upd_en) |=> $stable(st_q.stored));

    // R2
    jk_toggle_chk: assert property (@(posedge clk_mux) disable iff (clr_eff || set_eff)
        (cell_mode_e'(cfg_mode) == MODE_JK && upd_en && dsel && k_pt)
        |=> (st_q.stored != $past(st_q.stored)));

    // R2
    sr_hold_chk: assert property (@(posedge clk_mux) disable iff (clr_eff || set_eff)
        (cell_mode_e'(cfg_mode) == MODE_SR && upd_en && dsel && k_pt)
        |=> $stable(st_q.stored));

endmodule

// File: tb/sim_cellreg_top.sv
module sim_cellreg_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic       tb_clk = 1'b0;
    logic       rst_n;
    logic [2:0] gclk;
    logic       pt_clk;
    logic       gclr;
    logic [2:0] cfg_mode;
    logic [1:0] cfg_dsrc;
    logic [1:0] cfg_xsel;
    logic [1:0] cfg_clk_sel;
    logic       cfg_ce_on;
    logic [1:0] cfg_rst_sel;
    logic       cfg_pre_sel;
    logic       cfg_out_reg;
    logic       cfg_fb_reg;
    logic       sum_in, xor_pt, data_pt, pin_in, k_pt, ce_pt, ar_pt, ap_pt;
    logic       cell_out, fb_out;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    cellreg_top u0 (
        .rst_n(rst_n), .gclk(gclk), .pt_clk(pt_clk), .gclr(gclr),
        .cfg_mode(cfg_mode), .cfg_dsrc(cfg_dsrc), .cfg_xsel(cfg_xsel),
        .cfg_clk_sel(cfg_clk_sel), .cfg_ce_on(cfg_ce_on),
        .cfg_rst_sel(cfg_rst_sel), .cfg_pre_sel(cfg_pre_sel),
        .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
        .sum_in(sum_in), .xor_pt(xor_pt), .data_pt(data_pt), .pin_in(pin_in),
        .k_pt(k_pt), .ce_pt(ce_pt), .ar_pt(ar_pt), .ap_pt(ap_pt),
        .cell_out(cell_out), .fb_out(fb_out)
    );

    always #(CLK_PERIOD/2) tb_clk = ~tb_clk;

    always @(posedge tb_clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            done = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog all got=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b", req, got, exp);
        end
    endtask

    task automatic pulse(input int c);
        #2;
        if (c < 3) gclk[c] = 1'b1; else pt_clk = 1'b1;
        #3;
        if (c < 3) gclk[c] = 1'b0; else pt_clk = 1'b0;
        #3;
    endtask

    // Clock once more in D mode with the present value, so no flop edge
    // after a checked edge carries an unrelated state change.
    task automatic settle(input logic v);
        cfg_mode = 3'd0; cfg_dsrc = 2'd2; cfg_ce_on = 1'b0; pin_in = v;
        pulse(int'(cfg_clk_sel));
    endtask

    task automatic force_state(input logic v);
        cfg_rst_sel = 2'd2; cfg_pre_sel = 1'b1;
        #1;
        if (v) ap_pt = 1'b1; else ar_pt = 1'b1;
        #2;
        ap_pt = 1'b0; ar_pt = 1'b0;
        #1;
    endtask

    function automatic logic model(input int m, input logic q, input logic d, input logic k);
        case (m)
            0: return d;
            1: return q ^ d;
            2: return (d & ~q) | (~k & q);
            default: return (d && !k) ? 1'b1 : ((k && !d) ? 1'b0 : q);
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; gclk = '0; pt_clk = 1'b0; gclr = 1'b0;
        cfg_mode = 3'd0; cfg_dsrc = 2'd2; cfg_xsel = 2'd0; cfg_clk_sel = 2'd0;
        cfg_ce_on = 1'b0; cfg_rst_sel = 2'd0; cfg_pre_sel = 1'b0;
        cfg_out_reg = 1'b1; cfg_fb_reg = 1'b1;
        sum_in = 0; xor_pt = 0; data_pt = 0; pin_in = 1; k_pt = 0; ce_pt = 0;
        ar_pt = 0; ap_pt = 0;
        #3;
        pulse(0);
        check(cell_out, 1'b0, "R10 flop reset");
        cfg_mode = 3'd4; #1;
        check(cell_out, 1'b0, "R10 latch reset");
        cfg_mode = 3'd0;
        #5 rst_n = 1'b1;
        #5;

        // R2 update tables, rotating through all four clocks (R4)
        begin
            int it = 0;
            for (int m = 0; m < 4; m++)
                for (int q = 0; q < 2; q++)
                    for (int d = 0; d < 2; d++)
                        for (int k = 0; k < 2; k++) begin
                            logic e;
                            cfg_clk_sel = 2'(it % 4);
                            force_state(q[0]);
                            cfg_mode = 3'(m); cfg_dsrc = 2'd2;
                            pin_in = d[0]; k_pt = k[0];
                            pulse(it % 4);
                            e = model(m, q[0], d[0], k[0]);
                            check(cell_out, e, $sformatf("R2 mode%0d q%0d d%0d k%0d", m, q, d, k));
                            settle(e);
                            it++;
                        end
        end

        // R1 data source sweep, D mode, XOR second input = product term
        cfg_clk_sel = 2'd0; cfg_xsel = 2'd2;
        for (int s = 0; s < 3; s++)
            for (int p = 0; p < 16; p++) begin
                logic e;
                sum_in = p[0]; xor_pt = p[1]; data_pt = p[2];
                e = (s == 0) ? (p[0] ^ p[1]) : ((s == 1) ? p[2] : p[3]);
                force_state(~e);
                cfg_mode = 3'd0; cfg_dsrc = 2'(s); pin_in = p[3];
                pulse(0);
                check(cell_out, e, $sformatf("R1 src%0d pat%0d", s, p));
                settle(e);
            end

        // R9 XOR second input via combinational output
        cfg_out_reg = 1'b0;
        for (int x = 0; x < 3; x++)
            for (int p = 0; p < 4; p++) begin
                logic b;
                cfg_xsel = 2'(x); sum_in = p[0]; xor_pt = p[1];
                b = (x == 0) ? 1'b0 : ((x == 1) ? 1'b1 : p[1]);
                #1;
                check(cell_out, p[0] ^ b, $sformatf("R9 xsel%0d pat%0d", x, p));
            end
        cfg_out_reg = 1'b1;

        // R4 only the selected clock updates the state
        for (int c = 0; c < 4; c++) begin
            cfg_clk_sel = 2'(c);
            force_state(1'b0);
            cfg_mode = 3'd0; cfg_dsrc = 2'd2; pin_in = 1'b1;
            for (int o = 0; o < 4; o++) if (o != c) pulse(o);
            check(cell_out, 1'b0, $sformatf("R4 other clocks sel%0d", c));
            pulse(c);
            check(cell_out, 1'b1, $sformatf("R4 selected clock sel%0d", c));
            settle(1'b1);
        end

        // R5 clock enable
        cfg_clk_sel = 2'd1;
        force_state(1'b0);
        cfg_mode = 3'd0; pin_in = 1'b1; cfg_ce_on = 1'b1; ce_pt = 1'b0;
        pulse(1);
        check(cell_out, 1'b0, "R5 global blocked");
        cfg_ce_on = 1'b1; ce_pt = 1'b0; cfg_mode = 3'd0; pin_in = 1'b0;
        ce_pt = 1'b1; pulse(1);
        check(cell_out, 1'b0, "R5 global enabled d0");
        pin_in = 1'b1; pulse(1);
        check(cell_out, 1'b1, "R5 global enabled d1");
        settle(1'b1);
        cfg_clk_sel = 2'd3;
        force_state(1'b0);
        cfg_mode = 3'd0; pin_in = 1'b1; cfg_ce_on = 1'b1; ce_pt = 1'b0;
        pulse(3);
        check(cell_out, 1'b1, "R5 ce ignored on pt clock");
        settle(1'b1);
        cfg_clk_sel = 2'd2;
        force_state(1'b0);
        cfg_mode = 3'd0; pin_in = 1'b1; cfg_ce_on = 1'b0; ce_pt = 1'b0;
        pulse(2);
        check(cell_out, 1'b1, "R5 ce unused");
        settle(1'b1);

        // R3 latch
        cfg_clk_sel = 2'd0;
        force_state(1'b0);
        cfg_mode = 3'd4; cfg_dsrc = 2'd2; cfg_ce_on = 1'b0; pin_in = 1'b1;
        #2 gclk[0] = 1'b1; #2;
        check(cell_out, 1'b1, "R3 transparent d1");
        pin_in = 1'b0; #2;
        check(cell_out, 1'b0, "R3 transparent d0");
        pin_in = 1'b1; #2;
        gclk[0] = 1'b0; #2;
        pin_in = 1'b0; #2;
        check(cell_out, 1'b1, "R3 hold low clock");
        cfg_ce_on = 1'b1; ce_pt = 1'b0;
        gclk[0] = 1'b1; #2;
        check(cell_out, 1'b1, "R5 latch blocked by enable");
        ce_pt = 1'b1; #2;
        check(cell_out, 1'b0, "R3 latch enabled");
        gclk[0] = 1'b0; #2;
        settle(1'b0);

        // R6 clear source select
        for (int rs = 0; rs < 4; rs++)
            for (int p = 0; p < 4; p++) begin
                logic cl;
                force_state(1'b1);
                cfg_rst_sel = 2'(rs);
                #1 gclr = p[0]; ar_pt = p[1]; #2;
                cl = (rs[0] & p[0]) | (rs[1] & p[1]);
                check(cell_out, ~cl, $sformatf("R6 sel%0d gclr%0d ar%0d", rs, p[0], p[1]));
                gclr = 1'b0; ar_pt = 1'b0; #1;
            end

        // R7 preset select and priority
        force_state(1'b0);
        cfg_pre_sel = 1'b0;
        #1 ap_pt = 1'b1; #2;
        check(cell_out, 1'b0, "R7 preset disabled");
        ap_pt = 1'b0; #1;
        cfg_pre_sel = 1'b1;
        #1 ap_pt = 1'b1; #2;
        check(cell_out, 1'b1, "R7 preset enabled");
        ap_pt = 1'b0; #1;
        cfg_rst_sel = 2'd2;
        #1 ap_pt = 1'b1; ar_pt = 1'b1; #2;
        check(cell_out, 1'b0, "R7 clear wins");
        pin_in = 1'b1; pulse(0);
        check(cell_out, 1'b0, "R7 clear wins over clock");
        ar_pt = 1'b0; #2;
        check(cell_out, 1'b1, "R7 preset after clear release");
        ap_pt = 1'b0; #1;
        settle(1'b1);

        // R8 output and feedback selection
        force_state(1'b1);
        cfg_xsel = 2'd0; sum_in = 1'b0;
        cfg_out_reg = 1'b0; cfg_fb_reg = 1'b1; #1;
        check(cell_out, 1'b0, "R8 comb output");
        check(fb_out, 1'b1, "R8 registered feedback");
        cfg_out_reg = 1'b1; cfg_fb_reg = 1'b0; #1;
        check(cell_out, 1'b1, "R8 registered output");
        check(fb_out, 1'b0, "R8 comb feedback");
        sum_in = 1'b1; #1;
        check(fb_out, 1'b1, "R8 comb feedback follows sum");

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule